// File: doc/BRIEF.md
# Shared-Bus Configuration Front End

This block is the digital configuration front end of a sampled-data converter. Configuration words arrive on the same 10-bit bus that carries conversion results. A word is taken only while the converter's output drivers are switched off. In each word the two top bits name one of four registers, and the remaining bits carry the payload. The four registers are a low clamp byte, a high clamp pair, a control word and a reserved scratch register.

The write strobe is asynchronous. A two-flop synchroniser followed by an edge detector turns it into a one-cycle pulse on the system clock. The bus data and the output-disable level travel through matching pipeline stages, so the word that is stored is the one present when the strobe rose. The block decodes the stored values into these control outputs:

- a 10-bit clamp level, whose upper two bits choose one quarter of the reference span;
- an amplifier-off flag;
- the output number format;
- the clamp source;
- power down;
- a 3-bit gain code, together with the same gain expressed in half steps.

A wake-up state machine has three states: WK_ACTIVE (ready high), WK_ASLEEP and WK_WAKING. Its transitions are:

- **sleep**: WK_ACTIVE to WK_ASLEEP when power down is set.
- **release**: WK_ASLEEP to WK_WAKING when power down clears. The cycle counter is zeroed on this transition.
- **abort**: WK_WAKING to WK_ASLEEP when power down is set again during the wait.
- **expire**: WK_WAKING to WK_ACTIVE once the counter reaches WAKE_CYCLES-1.

A read-only debug port shows the raw contents of all four registers.

Top module: `cfgbus_front`

## Requirements
- R1: After reset, the clamp level is 0, and the amplifier-off, format, clamp-source and power-down outputs are 0. The gain code is 3'b001, the half-step gain is 2 and the ready flag is 1.
- R2: Bus bits 9:8 of a written word select the target: 2'b00 is the low clamp byte, 2'b01 is the high clamp pair, 2'b10 is the control word and 2'b11 is the scratch register. A write changes no other register.
- R3: A write to 2'b00 stores bus bits 7:0 as clamp bits 7:0. A write to 2'b01 stores bus bits 1:0 as clamp bits 9:8 and ignores bus bits 7:2. Neither write disturbs the other half of the clamp level.
- R4: clamp_level is {high pair, low byte}, and clamp_quarter equals the high pair.
- R5: A control write maps bus bit 6 to amp_off, bit 5 to fmt_twos (0 straight binary, 1 two's complement), bit 4 to clamp_internal (0 external, 1 internal) and bit 3 to pwr_down. Bits 2:0 go to gain_code.
- R6: gain_half equals gain_code + 1, giving values 1 to 8 that mean a gain of 0.5 to 4.0 in steps of 0.5.
- R7: A strobe whose rising edge is sampled while obus_hiz is 0 changes no register.
- R8: Only a rising strobe edge writes, and it writes exactly once. The stored value is the bus word sampled on the same clock edge that first sees the strobe high. Later bus changes while the strobe stays high have no effect. The new register value appears on the outputs after the third rising clock edge, counting that first edge as the first.
- R9: A scratch write updates dbg_test and changes no control output.
- R10: While the power-down register is 1, conv_ready is 0 from the next clock on. Once it clears, conv_ready rises exactly WAKE_CYCLES+1 clock edges after the edge that cleared it.
- R11: Setting power down again during the wake-up wait returns the machine to WK_ASLEEP. The next release starts a full wait from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 10 | Shared data bus as seen by the configuration logic |
| wr_strobe | input | 1 | Asynchronous write strobe; active on its rising edge |
| obus_hiz | input | 1 | 1 when the converter output drivers are off (writes allowed) |
| clamp_level | output | 10 | Combined clamp level |
| clamp_quarter | output | 2 | Reference quarter selected by the clamp level |
| amp_off | output | 1 | Clamp amplifier disabled |
| fmt_twos | output | 1 | Output format: 1 two's complement, 0 straight binary |
| clamp_internal | output | 1 | Clamp source: 1 internal digital level, 0 external |
| pwr_down | output | 1 | Power-down request |
| gain_code | output | 3 | Raw gain code |
| gain_half | output | 4 | Gain in half steps (code + 1) |
| conv_ready | output | 1 | Converter awake and ready |
| dbg_clamp_lo | output | 8 | Debug: low clamp byte |
| dbg_clamp_hi | output | 2 | Debug: high clamp pair |
| dbg_ctrl | output | 7 | Debug: control word |
| dbg_test | output | 8 | Debug: scratch register |

## Verification
The assertions check the following on every cycle:

- the synchroniser never emits two write pulses in a row;
- a write seen while the bus is driven leaves every register unchanged;
- scratch writes and high-pair writes leave the other registers intact;
- ready drops the cycle after power down is seen, rises only out of WK_WAKING, and the wake counter stays inside its window.

Some behaviours only the bench scenarios can show, against a cycle-by-cycle reference model:

- the exact three-edge write latency;
- which bus word is captured while the strobe is held high;
- the full field mapping and all eight gain codes;
- the exact WAKE_CYCLES+1 wake distance, including the restart after an aborted wake.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;

    localparam int SEL_W = 2;

    typedef enum logic [1:0] {
        SEL_CLAMP_LO = 2'b00,
        SEL_CLAMP_HI = 2'b01,
        SEL_CTRL     = 2'b10,
        SEL_TEST     = 2'b11
    } reg_sel_e;

    typedef enum logic [1:0] {
        WK_ACTIVE = 2'd0,
        WK_ASLEEP = 2'd1,
        WK_WAKING = 2'd2
    } wake_state_e;

    typedef struct packed {
        logic       amp_off;
        logic       fmt_twos;
        logic       clamp_int;
        logic       pwr_down;
        logic [2:0] gain;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{amp_off: 1'b0, fmt_twos: 1'b0, clamp_int: 1'b0,
                                     pwr_down: 1'b0, gain: 3'b001};

endpackage

// File: rtl/cfgbus_wr_sync.sv
module cfgbus_wr_sync #(
    parameter int BUS_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic [BUS_W-1:0] bus,
    input  logic             hiz,
    output logic             wr_pulse,
    output logic [BUS_W-1:0] wr_data,
    output logic             wr_hiz
);
    localparam int SYNC_D = 3;

    logic [SYNC_D-1:0] stb_q;
    logic [BUS_W-1:0]  d1_q, d2_q;
    logic              h1_q, h2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_q <= '0;
            d1_q  <= '0;
            d2_q  <= '0;
            h1_q  <= 1'b0;
            h2_q  <= 1'b0;
        end else begin
            stb_q <= {stb_q[SYNC_D-2:0], strobe};
            d1_q  <= bus;
            d2_q  <= d1_q;
            h1_q  <= hiz;
            h2_q  <= h1_q;
        end
    end

    assign wr_pulse = stb_q[1] & ~stb_q[2];
    assign wr_data  = d2_q;
    assign wr_hiz   = h2_q;

    // R8: a held strobe yields a single pulse
    assert_one_shot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

endmodule

// File: rtl/cfgbus_regs.sv
module cfgbus_regs
    import cfgbus_pkg::*;
#(
    parameter int BUS_W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_pulse,
    input  logic [BUS_W-1:0]     wr_data,
    input  logic                 wr_hiz,
    output logic [BUS_W-SEL_W-1:0] lo_q,
    output logic [1:0]           hi_q,
    output ctrl_t                ctrl_q,
    output logic [BUS_W-SEL_W-1:0] test_q
);
    localparam int PAY_W = BUS_W - SEL_W;

    reg_sel_e sel;
    logic     wr_en;

    assign sel   = reg_sel_e'(wr_data[BUS_W-1 -: SEL_W]);
    assign wr_en = wr_pulse & wr_hiz;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q   <= '0;
            hi_q   <= '0;
            ctrl_q <= CTRL_RESET;
            test_q <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_CLAMP_LO: lo_q   <= wr_data[PAY_W-1:0];
                SEL_CLAMP_HI: hi_q   <= wr_data[1:0];
                SEL_CTRL:     ctrl_q <= ctrl_t'(wr_data[6:0]);
                SEL_TEST:     test_q <= wr_data[PAY_W-1:0];
            endcase
        end
    end

    // R7: writes seen while the bus is driven are dropped
    assert_locked_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && !wr_hiz) |=>
            ($stable(lo_q) && $stable(hi_q) && $stable(ctrl_q) && $stable(test_q)));

    // R9: scratch writes leave every control source alone
    assert_test_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && wr_hiz && wr_data[BUS_W-1 -: SEL_W] == 2'b11) |=>
            ($stable(lo_q) && $stable(hi_q) && $stable(ctrl_q)));

    // R3: writing the high pair keeps the low byte
    assert_upper_keeps_lower_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && wr_hiz && wr_data[BUS_W-1 -: SEL_W] == 2'b01) |=> $stable(lo_q));

endmodule

// File: rtl/cfgbus_wake_fsm.sv
module cfgbus_wake_fsm
    import cfgbus_pkg::*;
#(
    parameter int WAKE_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_down,
    output logic ready
);
    localparam int CW = (WAKE_CYCLES < 2) ? 1 : $clog2(WAKE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WAKE_CYCLES - 1);

    wake_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            WK_ACTIVE: if (pwr_down) state_d = WK_ASLEEP;
            WK_ASLEEP: if (!pwr_down) begin
                state_d = WK_WAKING;
                cnt_d   = '0;
            end
            WK_WAKING: begin
                if (pwr_down)           state_d = WK_ASLEEP;
                else if (cnt_q == LAST) state_d = WK_ACTIVE;
                else                    cnt_d   = cnt_q + 1'b1;
            end
            default:   state_d = WK_ASLEEP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WK_ACTIVE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        ready = (state_q == WK_ACTIVE);
    end

    // R10: power down seen means not ready on the next cycle
    assert_sleep_blocks_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> !ready);

    // R11: ready only rises at the end of a wake-up wait
    assert_ready_after_wait_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(state_q == WK_WAKING));

    // R11: the wait counter never passes its limit
    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/cfgbus_front.sv
module cfgbus_front
    import cfgbus_pkg::*;
#(
    parameter int BUS_W       = 10,
    parameter int WAKE_CYCLES = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] bus_in,
    input  logic             wr_strobe,
    input  logic             obus_hiz,
    output logic [BUS_W-1:0] clamp_level,
    output logic [1:0]       clamp_quarter,
    output logic             amp_off,
    output logic             fmt_twos,
    output logic             clamp_internal,
    output logic             pwr_down,
    output logic [2:0]       gain_code,
    output logic [3:0]       gain_half,
    output logic             conv_ready,
    output logic [BUS_W-3:0] dbg_clamp_lo,
    output logic [1:0]       dbg_clamp_hi,
    output logic [6:0]       dbg_ctrl,
    output logic [BUS_W-3:0] dbg_test
);
    localparam int PAY_W = BUS_W - SEL_W;

    logic             wr_pulse, wr_hiz;
    logic [BUS_W-1:0] wr_data;
    logic [PAY_W-1:0] lo_q, test_q;
    logic [1:0]       hi_q;
    ctrl_t            ctrl_q;

    cfgbus_wr_sync #(.BUS_W(BUS_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .strobe(wr_strobe), .bus(bus_in), .hiz(obus_hiz),
        .wr_pulse(wr_pulse), .wr_data(wr_data), .wr_hiz(wr_hiz)
    );

    cfgbus_regs #(.BUS_W(BUS_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .wr_data(wr_data), .wr_hiz(wr_hiz),
        .lo_q(lo_q), .hi_q(hi_q), .ctrl_q(ctrl_q), .test_q(test_q)
    );

    cfgbus_wake_fsm #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
        .clk(clk), .rst_n(rst_n), .pwr_down(ctrl_q.pwr_down), .ready(conv_ready)
    );

    assign clamp_level    = {hi_q, lo_q};
    assign clamp_quarter  = hi_q;
    assign amp_off        = ctrl_q.amp_off;
    assign fmt_twos       = ctrl_q.fmt_twos;
    assign clamp_internal = ctrl_q.clamp_int;
    assign pwr_down       = ctrl_q.pwr_down;
    assign gain_code      = ctrl_q.gain;
    assign gain_half      = {1'b0, ctrl_q.gain} + 4'd1;
    assign dbg_clamp_lo   = lo_q;
    assign dbg_clamp_hi   = hi_q;
    assign dbg_ctrl       = ctrl_q;
    assign dbg_test       = test_q;

endmodule

// File: tb/cfgbus_front_tb_top.sv
module cfgbus_front_tb_top;
    localparam int W = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] bus_in = '0;
    logic       wr_strobe = 1'b0;
    logic       obus_hiz = 1'b1;
    logic [9:0] clamp_level;
    logic [1:0] clamp_quarter;
    logic       amp_off, fmt_twos, clamp_internal, pwr_down, conv_ready;
    logic [2:0] gain_code;
    logic [3:0] gain_half;
    logic [7:0] dbg_clamp_lo, dbg_test;
    logic [1:0] dbg_clamp_hi;
    logic [6:0] dbg_ctrl;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    cfgbus_front #(.BUS_W(10), .WAKE_CYCLES(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .wr_strobe(wr_strobe), .obus_hiz(obus_hiz),
        .clamp_level(clamp_level), .clamp_quarter(clamp_quarter), .amp_off(amp_off),
        .fmt_twos(fmt_twos), .clamp_internal(clamp_internal), .pwr_down(pwr_down),
        .gain_code(gain_code), .gain_half(gain_half), .conv_ready(conv_ready),
        .dbg_clamp_lo(dbg_clamp_lo), .dbg_clamp_hi(dbg_clamp_hi), .dbg_ctrl(dbg_ctrl),
        .dbg_test(dbg_test)
    );

    // ---------------- reference model ----------------
    logic [7:0]  m_lo, m_test;
    logic [1:0]  m_hi;
    logic [6:0]  m_ctrl;
    int          m_state;   // 0 ready, 1 asleep, 2 waiting
    int          m_cnt;
    logic [11:0] hist[$];   // {strobe, hiz, bus} seen at each edge, newest first

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lo = 0; m_hi = 0; m_ctrl = 7'b0000001; m_test = 0;
            m_state = 0; m_cnt = 0;
            hist = '{12'h0, 12'h0, 12'h0, 12'h0};
        end else begin
            // wake-up timeline from the power-down value held so far
            if (m_state == 0) begin
                if (m_ctrl[3]) m_state = 1;
            end else if (m_state == 1) begin
                if (!m_ctrl[3]) begin m_state = 2; m_cnt = 0; end
            end else begin
                if (m_ctrl[3]) m_state = 1;
                else if (m_cnt == W - 1) m_state = 0;
                else m_cnt = m_cnt + 1;
            end
            hist.push_front({wr_strobe, obus_hiz, bus_in});
            if (hist.size() > 4) void'(hist.pop_back());
            if (hist[2][11] && !hist[3][11] && hist[2][10]) begin
                case (hist[2][9:8])
                    2'b00: m_lo   = hist[2][7:0];
                    2'b01: m_hi   = hist[2][1:0];
                    2'b10: m_ctrl = hist[2][6:0];
                    default: m_test = hist[2][7:0];
                endcase
            end
        end
        #1;
        if (rst_n) begin
            automatic bit bad = 0;
            checks++;
            if (clamp_level !== {m_hi, m_lo} || clamp_quarter !== m_hi) begin
                $display("FAIL R4 clamp act=%h/%0d exp=%h/%0d", clamp_level, clamp_quarter, {m_hi, m_lo}, m_hi);
                bad = 1;
            end
            if ({amp_off, fmt_twos, clamp_internal, pwr_down, gain_code} !== m_ctrl) begin
                $display("FAIL R5 ctrl act=%b exp=%b", {amp_off, fmt_twos, clamp_internal, pwr_down, gain_code}, m_ctrl);
                bad = 1;
            end
            if (gain_half !== {1'b0, m_ctrl[2:0]} + 4'd1) begin
                $display("FAIL R6 gain_half act=%0d exp=%0d", gain_half, m_ctrl[2:0] + 1);
                bad = 1;
            end
            if (conv_ready !== (m_state == 0)) begin
                $display("FAIL R10 ready act=%b exp=%b", conv_ready, m_state == 0);
                bad = 1;
            end
            if (dbg_clamp_lo !== m_lo || dbg_clamp_hi !== m_hi || dbg_ctrl !== m_ctrl || dbg_test !== m_test) begin
                $display("FAIL R2 debug act=%h %h %h %h exp=%h %h %h %h",
                         dbg_clamp_lo, dbg_clamp_hi, dbg_ctrl, dbg_test, m_lo, m_hi, m_ctrl, m_test);
                bad = 1;
            end
            if (bad) fails++;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [9:0] w, input logic hiz);
        @(negedge clk); bus_in = w; obus_hiz = hiz;
        @(negedge clk); wr_strobe = 1'b1;
        repeat (3) @(negedge clk);
        wr_strobe = 1'b0;
        repeat (3) @(negedge clk);
        obus_hiz = 1'b1;
        bus_in = 10'h3FF;
    endtask

    task automatic wait_settle();
        repeat (2) @(negedge clk);
    endtask

    int n;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        chk("R1 clamp_level", clamp_level, 0);
        chk("R1 gain_code", gain_code, 1);
        chk("R1 gain_half", gain_half, 2);
        chk("R1 flags", {amp_off, fmt_twos, clamp_internal, pwr_down}, 0);
        chk("R1 ready", conv_ready, 1);

        // R2/R3 low byte
        bus_write(10'b00_1010_0101, 1'b1); wait_settle();
        chk("R3 low byte", clamp_level, 10'h0A5);
        // R3 high pair, upper payload bits ignored, R4 quarter
        bus_write(10'b01_1111_1110, 1'b1); wait_settle();
        chk("R3 high pair", clamp_level, 10'h2A5);
        chk("R4 quarter", clamp_quarter, 2);
        // R5 control fields
        bus_write(10'b10_0111_0101, 1'b1); wait_settle();
        chk("R5 amp_off", amp_off, 1);
        chk("R5 fmt_twos", fmt_twos, 1);
        chk("R5 clamp_internal", clamp_internal, 1);
        chk("R5 gain_code", gain_code, 5);
        chk("R2 clamp untouched", clamp_level, 10'h2A5);
        // R6 all gain codes
        for (int g = 0; g < 8; g++) begin
            bus_write({2'b10, 5'b0, 3'(g)}, 1'b1); wait_settle();
            chk("R6 gain_half", gain_half, g + 1);
        end
        // R7 write while bus driven is dropped
        bus_write(10'b00_0011_1100, 1'b0); wait_settle();
        chk("R7 dropped write", clamp_level, 10'h2A5);
        // R9 scratch write
        bus_write(10'b11_0101_1010, 1'b1); wait_settle();
        chk("R9 dbg_test", dbg_test, 8'h5A);
        chk("R9 clamp same", clamp_level, 10'h2A5);
        chk("R9 gain same", gain_code, 7);
        // R8 held strobe, data changes while high: first word wins, exact latency
        @(negedge clk); bus_in = 10'b00_0001_0001;
        @(negedge clk); wr_strobe = 1'b1;
        @(posedge clk); #1; chk("R8 not yet 1", clamp_level, 10'h2A5);
        @(negedge clk); bus_in = 10'b00_1110_1110;
        @(posedge clk); #1; chk("R8 not yet 2", clamp_level, 10'h2A5);
        @(posedge clk); #1; chk("R8 third edge", clamp_level, 10'h211);
        repeat (8) @(negedge clk);
        chk("R8 single write", clamp_level, 10'h211);
        wr_strobe = 1'b0;
        wait_settle();

        // R10 power down then wake distance
        bus_write(10'b10_0000_1001, 1'b1); wait_settle();
        chk("R10 asleep", conv_ready, 0);
        fork bus_write(10'b10_0000_0001, 1'b1); join_none
        n = 0;
        do begin @(posedge clk); #1; n++; end while (pwr_down && n < 50);
        n = 0;
        do begin @(posedge clk); #1; n++; end while (!conv_ready && n < 200);
        chk("R10 wake distance", n, W + 1);
        wait_settle();

        // R11 abort during wake, then full restart
        bus_write(10'b10_0000_1001, 1'b1);
        bus_write(10'b10_0000_0001, 1'b1);
        bus_write(10'b10_0000_1001, 1'b1); wait_settle();
        chk("R11 abort keeps low", conv_ready, 0);
        fork bus_write(10'b10_0000_0001, 1'b1); join_none
        n = 0;
        do begin @(posedge clk); #1; n++; end while (pwr_down && n < 50);
        n = 0;
        do begin @(posedge clk); #1; n++; end while (!conv_ready && n < 200);
        chk("R11 restart distance", n, W + 1);
        wait_settle();

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule